// File: doc/BRIEF.md
# ADC Result Justification Register

This block sits between an analog-to-digital converter core and the register bus. Each time the converter reports a finished 10-bit sample, the block places the sample into a pair of 8-bit readable registers, a high byte and a low byte. A 2-bit mode input picks the layout. The sample can be packed toward the top of the high byte, packed toward the bottom of the low byte, packed toward the top with its most significant bit inverted for signed data, or cut down to its eight upper bits in the low byte.

In the three two-byte layouts, a guard keeps the two bytes coherent. Reading the high byte arms the guard. While it is armed, any finished sample is discarded and is not queued. Reading the low byte releases the guard. The 8-bit layout has no guard, so every finished sample lands at once. A sticky flag tells software that a stored result has not yet been fully read.

Top module: `adc_result_fmt`

## Requirements
- R1: Mode 00 (top-packed): high byte = sample[9:2], low byte = {sample[1:0], 6'b0}.
- R2: Mode 01 (bottom-packed): high byte = {6'b0, sample[9:8]}, low byte = sample[7:0].
- R3: Mode 10 (signed top-packed): high byte = {~sample[9], sample[8:2]}, low byte = {sample[1:0], 6'b0}.
- R4: Mode 11 (8-bit): low byte = sample[9:2] and high byte reads zero. The two lowest sample bits are lost.
- R5: In modes 00, 01 and 10, a high-byte read arms the guard. A sample that finishes while the guard is armed, or in the same cycle as the high-byte read, is dropped and never stored later.
- R6: A low-byte read releases the guard, and the next finished sample is stored.
- R7: In mode 11, a high-byte read does not arm the guard. Every finished sample updates the low byte.
- R8: The valid flag is set by each stored sample and cleared by a low-byte read. If a store and a low-byte read fall in the same cycle, the flag stays set.
- R9: A change of the mode input releases the guard. The new mode is applied to the next stored sample.
- R10: After reset, both bytes read zero, the flag is clear, the guard is released and the remembered mode is 00.
- R11: A stored sample appears on the byte outputs in the cycle after its completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | One-cycle strobe: a sample has finished |
| convData | input | 10 | Finished sample value |
| modeSel | input | 2 | Layout select: 00 top, 01 bottom, 10 signed top, 11 8-bit |
| rdHigh | input | 1 | Read strobe for the high byte |
| rdLow | input | 1 | Read strobe for the low byte |
| regHigh | output | 8 | High byte contents |
| regLow | output | 8 | Low byte contents |
| resultValid | output | 1 | Sticky flag: a stored result is not fully read |

## Verification
The hardest states to reach are the ones where a finished sample collides with the guard. These are a sample in the same cycle as the high-byte read, a sample while the guard is armed, a sample in the same cycle as the low-byte read, and a mode change while the guard is armed. The directed stimulus arms the guard with a high-byte read and then times each strobe to a chosen cycle. After each strobe it checks that the held bytes keep the earlier sample. After the guard is released, it checks that the dropped sample never appears.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_TOP    = 2'b00,
    FMT_BOTTOM = 2'b01,
    FMT_SIGNED = 2'b10,
    FMT_BYTE   = 2'b11
  } fmtMode_t;

  typedef struct packed {
    logic     store;
    fmtMode_t fmtMode;
  } dpCtrl_t;
endpackage

// File: rtl/adc_fmt_ctrl.sv
module adc_fmt_ctrl
  import adc_fmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     convDone,
  input  logic [1:0] modeSel,
  input  logic     rdHigh,
  input  logic     rdLow,
  output dpCtrl_t  dpCtrl,
  output logic     lockArmed,
  output logic     resultValid
);
  fmtMode_t curMode;
  fmtMode_t lastMode;
  logic     modeChange;
  logic     multiByte;
  logic     blocked;
  logic     storeNow;

  assign curMode    = fmtMode_t'(modeSel);
  assign modeChange = (curMode != lastMode);
  assign multiByte  = (curMode != FMT_BYTE);
  // reads of the high byte in this cycle also protect the pair
  assign blocked    = multiByte && !modeChange && (lockArmed || rdHigh) && !rdLow;
  assign storeNow   = convDone && !blocked;

  assign dpCtrl.store   = storeNow;
  assign dpCtrl.fmtMode = curMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastMode    <= FMT_TOP;
      lockArmed   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      lastMode <= curMode;
      if (modeChange || !multiByte || rdLow)
        lockArmed <= 1'b0;
      else if (rdHigh)
        lockArmed <= 1'b1;
      if (storeNow)
        resultValid <= 1'b1;
      else if (rdLow)
        resultValid <= 1'b0;
    end
  end

  // R9
  mode_change_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeChange |=> !lockArmed);

  // R7
  byte_mode_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == 2'b11) |=> !lockArmed || (modeSel != 2'b11));
endmodule

// File: rtl/adc_fmt_datapath.sv
module adc_fmt_datapath
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           dpCtrl,
  input  logic [RES_W-1:0]  convData,
  output logic [BYTE_W-1:0] regHigh,
  output logic [BYTE_W-1:0] regLow
);
  localparam int SPILL_W = RES_W - BYTE_W;
  localparam int PAD_W   = BYTE_W - SPILL_W;

  logic [BYTE_W-1:0] topByte;
  logic [BYTE_W-1:0] nextHigh;
  logic [BYTE_W-1:0] nextLow;

  assign topByte = convData[RES_W-1 -: BYTE_W];

  always_comb begin
    nextHigh = '0;
    nextLow  = '0;
    unique case (dpCtrl.fmtMode)
      FMT_TOP: begin
        nextHigh = topByte;
        nextLow  = {convData[SPILL_W-1:0], {PAD_W{1'b0}}};
      end
      FMT_BOTTOM: begin
        nextHigh = {{PAD_W{1'b0}}, convData[RES_W-1 -: SPILL_W]};
        nextLow  = convData[BYTE_W-1:0];
      end
      FMT_SIGNED: begin
        nextHigh = {~topByte[BYTE_W-1], topByte[BYTE_W-2:0]};
        nextLow  = {convData[SPILL_W-1:0], {PAD_W{1'b0}}};
      end
      FMT_BYTE: begin
        nextHigh = '0;
        nextLow  = topByte;
      end
      default: begin
        nextHigh = '0;
        nextLow  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regHigh <= '0;
      regLow  <= '0;
    end else if (dpCtrl.store) begin
      regHigh <= nextHigh;
      regLow  <= nextLow;
    end
  end

  // R4
  byte_mode_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dpCtrl.store && dpCtrl.fmtMode == FMT_BYTE) |=> (regHigh == '0));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_fmt_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  input  logic [1:0]        modeSel,
  input  logic              rdHigh,
  input  logic              rdLow,
  output logic [BYTE_W-1:0] regHigh,
  output logic [BYTE_W-1:0] regLow,
  output logic              resultValid
);
  dpCtrl_t dpCtrl;
  logic    lockArmed;

  adc_fmt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .convDone(convDone), .modeSel(modeSel),
    .rdHigh(rdHigh), .rdLow(rdLow), .dpCtrl(dpCtrl),
    .lockArmed(lockArmed), .resultValid(resultValid)
  );

  adc_fmt_datapath #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl), .convData(convData),
    .regHigh(regHigh), .regLow(regLow)
  );

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockArmed && convDone && !rdLow && modeSel != 2'b11 && $stable(modeSel))
      |=> ($stable(regHigh) && $stable(regLow)));

  // R11
  byte_mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (convDone && modeSel == 2'b11)
      |=> (regLow == $past(convData[RES_W-1 -: BYTE_W])));

  // R8
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resultValid) |-> $past(convDone));

  // R8
  valid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdLow && !convDone) |=> !resultValid);
endmodule

// File: tb/adc_result_fmt_tb.sv
module adc_result_fmt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       convDone = 1'b0;
  logic [9:0] convData = '0;
  logic [1:0] modeSel = 2'b00;
  logic       rdHigh = 1'b0;
  logic       rdLow = 1'b0;
  logic [7:0] regHigh;
  logic [7:0] regLow;
  logic       resultValid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_result_fmt u_dut (
    .clk(clk), .rst_n(rst_n), .convDone(convDone), .convData(convData),
    .modeSel(modeSel), .rdHigh(rdHigh), .rdLow(rdLow),
    .regHigh(regHigh), .regLow(regLow), .resultValid(resultValid)
  );

  // {mode, sample, expected high, expected low}
  localparam int NVEC = 10;
  localparam logic [27:0] VEC [NVEC] = '{
    {2'b00, 10'h2A5, 8'hA9, 8'h40},
    {2'b01, 10'h2A5, 8'h02, 8'hA5},
    {2'b10, 10'h2A5, 8'h29, 8'h40},
    {2'b11, 10'h2A5, 8'h00, 8'hA9},
    {2'b00, 10'h3FF, 8'hFF, 8'hC0},
    {2'b10, 10'h3FF, 8'h7F, 8'hC0},
    {2'b01, 10'h001, 8'h00, 8'h01},
    {2'b10, 10'h200, 8'h00, 8'h00},
    {2'b11, 10'h3FF, 8'h00, 8'hFF},
    {2'b00, 10'h001, 8'h00, 8'h40}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic conv(input logic [9:0] d);
    @(negedge clk);
    convDone = 1'b1; convData = d;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic readHi();
    @(negedge clk); rdHigh = 1'b1;
    @(negedge clk); rdHigh = 1'b0;
  endtask

  task automatic readLo();
    @(negedge clk); rdLow = 1'b1;
    @(negedge clk); rdLow = 1'b0;
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk); modeSel = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 high", regHigh, 8'h00);
    check("R10 low", regLow, 8'h00);
    check("R10 valid", {7'b0, resultValid}, 8'h00);
    rst_n = 1'b1;
    idle();

    // R1 R2 R3 R4 R11 table walk
    for (int i = 0; i < NVEC; i++) begin
      setMode(VEC[i][27:26]);
      conv(VEC[i][25:16]);
      check($sformatf("R11 vec%0d high", i), regHigh, VEC[i][15:8]);
      check($sformatf("R11 vec%0d low", i), regLow, VEC[i][7:0]);
      check($sformatf("R8 vec%0d set", i), {7'b0, resultValid}, 8'h01);
      readHi();
      readLo();
      check($sformatf("R8 vec%0d clr", i), {7'b0, resultValid}, 8'h00);
    end

    // R5 drop while armed, R6 release
    setMode(2'b00);
    conv(10'h155);                    // high 0x55, low 0x40
    readHi();
    conv(10'h3C3);
    check("R5 held high", regHigh, 8'h55);
    check("R5 held low", regLow, 8'h40);
    readLo();
    idle();
    check("R5 not queued", regHigh, 8'h55);
    conv(10'h3C3);                    // high 0xF0, low 0xC0
    check("R6 stored high", regHigh, 8'hF0);
    check("R6 stored low", regLow, 8'hC0);

    // R5 sample in same cycle as high read
    readLo();
    @(negedge clk); rdHigh = 1'b1; convDone = 1'b1; convData = 10'h004;
    @(negedge clk); rdHigh = 1'b0; convDone = 1'b0;
    check("R5 same-cycle drop", regHigh, 8'hF0);
    readLo();

    // R8 store and low read in the same cycle
    @(negedge clk); rdLow = 1'b1; convDone = 1'b1; convData = 10'h0FC;
    @(negedge clk); rdLow = 1'b0; convDone = 1'b0;
    check("R8 set wins", {7'b0, resultValid}, 8'h01);
    check("R8 new data", regHigh, 8'h3F);
    readLo();

    // R7 no guard in 8-bit mode
    setMode(2'b11);
    conv(10'h100);
    readHi();
    conv(10'h2F0);
    check("R7 updates", regLow, 8'hBC);
    check("R4 high zero", regHigh, 8'h00);
    readLo();

    // R9 mode change releases guard and applies to next store
    setMode(2'b00);
    conv(10'h0FF);
    readHi();
    setMode(2'b01);
    conv(10'h2A5);
    check("R9 new mode high", regHigh, 8'h02);
    check("R9 new mode low", regLow, 8'hA5);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule